// File: doc/BRIEF.md
# Windowed Framebuffer Write Addresser

This block tracks where the next pixel byte goes in a 4-bit-per-pixel display memory. The memory is 64 byte columns wide and 80 rows deep, and each byte carries two pixels. A command parser upstream loads a rectangular write window: a first and last column, and a first and last row. It also loads a configuration byte that selects whether the write position moves along a row first or down a column first. Each byte strobe in data mode produces a memory write enable and a linear address in the same cycle. The position then advances at the next clock edge and wraps back inside the window on both axes.

Every accepted byte also raises a redraw flag. The scan-out logic clears this flag after it has refreshed the frame. Command decoding, the memory array and the scan-out path sit outside this block.

Top module: `fbw_addresser`

## Requirements
- R1: After reset the write position is column 0, row 0, the window spans columns 0..63 and rows 0..79, the mode is row-first (horizontal), and `redraw` is 0.
- R2: When `byte_strobe` is high and no window load is active, `mem_we` is 1 in that same cycle, `mem_addr` equals row*64 + column of the current position, and `mem_wdata` equals `byte_in`. Otherwise `mem_we` is 0.
- R3: In horizontal mode an accepted byte moves the column up by one. When the new column would exceed the last column, the column returns to the first column and the row moves up by one. When the row would then exceed the last row, it returns to the first row.
- R4: Bit 2 of `remap_byte`, captured when `remap_load` is high, selects vertical mode (1) or horizontal mode (0). In vertical mode the row steps first and wraps to the first row, and on that wrap the column steps and wraps to the first column.
- R5: `col_load` sets both the current and first column to `col_first` mod 64, and sets the last column to `col_last` mod 64.
- R6: `row_load` sets both the current and first row to `row_first` mod 80, and sets the last row to `row_last` mod 80.
- R7: A byte strobe in a cycle where `col_load` or `row_load` is high is discarded. There is no write enable, no position step and no redraw; the load takes effect.
- R8: `redraw` becomes 1 in the cycle after an accepted byte. It becomes 0 in the cycle after `redraw_clr` when no byte is accepted. If both happen in the same cycle, the set wins.
- R9: If the first bound of an axis is greater than its last bound, every step on that axis returns to the first bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_strobe | input | 1 | Pixel byte present (data mode) |
| byte_in | input | 8 | Pixel byte, two 4-bit pixels |
| remap_load | input | 1 | Capture configuration byte |
| remap_byte | input | 8 | Configuration byte; bit 2 selects vertical mode |
| col_load | input | 1 | Load column window |
| col_first | input | 8 | First column argument (mod 64) |
| col_last | input | 8 | Last column argument (mod 64) |
| row_load | input | 1 | Load row window |
| row_first | input | 8 | First row argument (mod 80) |
| row_last | input | 8 | Last row argument (mod 80) |
| redraw_clr | input | 1 | Scan-out has refreshed the frame |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 13 | Linear memory byte address |
| mem_wdata | output | 8 | Memory write data |
| redraw | output | 1 | Frame content changed since last refresh |

## Verification
The write enable, address and data are combinational from the strobe and the current position, so they are due in the same cycle as the strobe. The bench samples them two nanoseconds after it drives its inputs, well before the rising edge. The position step, window loads, mode capture and redraw flag each pass through one register, so their effects show up one cycle later. The bench updates its own model only after the rising edge, and its next sample catches them there.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  // Reduce a loaded argument into the legal range of an axis.
  function automatic int unsigned arg_mod(int unsigned v, int unsigned lim);
    return v % lim;
  endfunction

  // Linear byte index of a position inside a row-major memory.
  function automatic int unsigned lin_index(int unsigned col, int unsigned row,
                                            int unsigned cols);
    return row * cols + col;
  endfunction

  // Select one bit of a configuration byte.
  function automatic logic pick_bit(logic [7:0] v, int unsigned b);
    return v[b];
  endfunction

endpackage

// File: rtl/fbw_axis.sv
module fbw_axis #(
  parameter int LIMIT = 64,
  parameter int ARG_W = 8,
  localparam int PW   = $clog2(LIMIT)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ARG_W-1:0] first_arg,
  input  logic [ARG_W-1:0] last_arg,
  input  logic             advance,
  output logic [PW-1:0]    pos,
  output logic             wrap
);
  logic [PW-1:0] start_q, end_q, pos_q;
  logic [PW:0]   bump;

  assign bump = {1'b0, pos_q} + {{PW{1'b0}}, 1'b1};
  assign wrap = bump > {1'b0, end_q};
  assign pos  = pos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      start_q <= '0;
      end_q   <= PW'(LIMIT - 1);
    end else if (load) begin
      pos_q   <= PW'(fbw_pkg::arg_mod(32'(first_arg), LIMIT));
      start_q <= PW'(fbw_pkg::arg_mod(32'(first_arg), LIMIT));
      end_q   <= PW'(fbw_pkg::arg_mod(32'(last_arg), LIMIT));
    end else if (advance) begin
      pos_q   <= wrap ? start_q : bump[PW-1:0];
    end
  end
endmodule

// File: rtl/fbw_flag.sv
module fbw_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end
endmodule

// File: rtl/fbw_addresser.sv
module fbw_addresser #(
  parameter int COLS     = 64,
  parameter int ROWS     = 80,
  parameter int ARG_W    = 8,
  parameter int PIX_W    = 8,
  parameter int MODE_BIT = 2,
  localparam int CW      = $clog2(COLS),
  localparam int RW      = $clog2(ROWS),
  localparam int AW      = $clog2(COLS * ROWS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_strobe,
  input  logic [PIX_W-1:0] byte_in,
  input  logic             remap_load,
  input  logic [7:0]       remap_byte,
  input  logic             col_load,
  input  logic [ARG_W-1:0] col_first,
  input  logic [ARG_W-1:0] col_last,
  input  logic             row_load,
  input  logic [ARG_W-1:0] row_first,
  input  logic [ARG_W-1:0] row_last,
  input  logic             redraw_clr,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [PIX_W-1:0] mem_wdata,
  output logic             redraw
);
  logic          vert_mode;
  logic          win_load;
  logic          wr_accept;
  logic          col_adv, row_adv;
  logic          col_wrap, row_wrap;
  logic [CW-1:0] col_pos;
  logic [RW-1:0] row_pos;

  // Direction select, captured from the configuration byte.
  always_ff @(posedge clk) begin
    if (!rst_n)          vert_mode <= 1'b0;
    else if (remap_load) vert_mode <= fbw_pkg::pick_bit(remap_byte, MODE_BIT);
  end

  // A window load in the same cycle discards the byte.
  assign win_load  = col_load | row_load;
  assign wr_accept = byte_strobe & ~win_load;

  // The inner axis steps on every byte; the outer one only on inner wrap.
  assign col_adv = wr_accept & (vert_mode ? row_wrap : 1'b1);
  assign row_adv = wr_accept & (vert_mode ? 1'b1 : col_wrap);

  fbw_axis #(.LIMIT(COLS), .ARG_W(ARG_W)) u_col (
    .clk(clk), .rst_n(rst_n), .load(col_load),
    .first_arg(col_first), .last_arg(col_last),
    .advance(col_adv), .pos(col_pos), .wrap(col_wrap)
  );

  fbw_axis #(.LIMIT(ROWS), .ARG_W(ARG_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load(row_load),
    .first_arg(row_first), .last_arg(row_last),
    .advance(row_adv), .pos(row_pos), .wrap(row_wrap)
  );

  fbw_flag u_redraw (
    .clk(clk), .rst_n(rst_n), .set(wr_accept), .clr(redraw_clr), .flag(redraw)
  );

  assign mem_we    = wr_accept;
  assign mem_addr  = AW'(fbw_pkg::lin_index(32'(col_pos), 32'(row_pos), COLS));
  assign mem_wdata = byte_in;
endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
  parameter int COLS = 64,
  parameter int ROWS = 80,
  parameter int ARG_W = 8,
  localparam int CW = $clog2(COLS),
  localparam int RW = $clog2(ROWS)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             byte_strobe,
  input logic             win_load,
  input logic             mem_we,
  input logic             redraw,
  input logic             redraw_clr,
  input logic             col_load,
  input logic [ARG_W-1:0] col_first,
  input logic             vert_mode,
  input logic             col_wrap,
  input logic             row_wrap,
  input logic [CW-1:0]    col_pos,
  input logic [RW-1:0]    row_pos
);
  p_load_blocks_we_r7: assert property (@(posedge clk) disable iff (!rst_n)
    win_load |-> !mem_we);

  p_we_needs_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> byte_strobe);

  p_redraw_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> redraw);

  p_redraw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (redraw_clr && !mem_we) |=> !redraw);

  p_row_in_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_pos) < ROWS);

  p_col_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    col_load |=> int'(col_pos) == int'($past(col_first)) % COLS);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!byte_strobe && !win_load) |=> ($stable(col_pos) && $stable(row_pos)));

  p_horiz_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !vert_mode && !col_wrap) |=>
      (col_pos == $past(col_pos) + 1'b1) && $stable(row_pos));

  p_vert_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && vert_mode && !row_wrap) |=>
      (row_pos == $past(row_pos) + 1'b1) && $stable(col_pos));
endmodule

bind fbw_addresser fbw_checker #(.COLS(COLS), .ROWS(ROWS), .ARG_W(ARG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .byte_strobe(byte_strobe), .win_load(win_load),
  .mem_we(mem_we), .redraw(redraw), .redraw_clr(redraw_clr),
  .col_load(col_load), .col_first(col_first), .vert_mode(vert_mode),
  .col_wrap(col_wrap), .row_wrap(row_wrap), .col_pos(col_pos), .row_pos(row_pos)
);

// File: tb/sim_fbw_addresser.sv
`timescale 1ns/1ps
module sim_fbw_addresser;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic byte_strobe = 0, remap_load = 0, col_load = 0, row_load = 0, redraw_clr = 0;
  logic [7:0] byte_in = 0, remap_byte = 0, col_first = 0, col_last = 0, row_first = 0, row_last = 0;
  logic mem_we, redraw;
  logic [12:0] mem_addr;
  logic [7:0] mem_wdata;

  always #10 clk = ~clk;

  fbw_addresser u0 (
    .clk(clk), .rst_n(rst_n), .byte_strobe(byte_strobe), .byte_in(byte_in),
    .remap_load(remap_load), .remap_byte(remap_byte),
    .col_load(col_load), .col_first(col_first), .col_last(col_last),
    .row_load(row_load), .row_first(row_first), .row_last(row_last),
    .redraw_clr(redraw_clr), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .redraw(redraw)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  int m_col, m_row, m_cs, m_ce, m_rs, m_re;
  bit m_vert, m_redraw;

  function automatic int red80(int v);
    int r = v;
    while (r >= 80) r -= 80;
    return r;
  endfunction

  function automatic int exp_addr(int c, int r);
    return (r << 6) | c;
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic model_reset();
    m_col = 0; m_row = 0; m_cs = 0; m_ce = 63; m_rs = 0; m_re = 79;
    m_vert = 0; m_redraw = 0;
  endtask

  // One cycle: drive after negedge, sample before posedge, update model after it.
  task automatic cyc(bit s, logic [7:0] d, bit gl, logic [7:0] gb,
                     bit cl, logic [7:0] cf, logic [7:0] ct,
                     bit rl, logic [7:0] rf, logic [7:0] rt, bit clr, string tag);
    bit acc;
    byte_strobe = s; byte_in = d; remap_load = gl; remap_byte = gb;
    col_load = cl; col_first = cf; col_last = ct;
    row_load = rl; row_first = rf; row_last = rt; redraw_clr = clr;
    acc = s && !cl && !rl;
    #2;
    check((s && !acc) ? "R7" : tag, "mem_we", int'(mem_we), int'(acc));
    if (acc) begin
      check(tag, "mem_addr", int'(mem_addr), exp_addr(m_col, m_row));
      check("R2", "mem_wdata", int'(mem_wdata), int'(d));
    end
    check("R8", "redraw", int'(redraw), int'(m_redraw));
    @(posedge clk);
    if (cl) begin m_cs = cf & 63; m_col = m_cs; m_ce = ct & 63; end
    if (rl) begin m_rs = red80(rf); m_row = m_rs; m_re = red80(rt); end
    if (acc) begin
      if (m_vert) begin
        m_row = m_row + 1;
        if (m_row > m_re) begin
          m_row = m_rs; m_col = m_col + 1;
          if (m_col > m_ce) m_col = m_cs;
        end
      end else begin
        m_col = m_col + 1;
        if (m_col > m_ce) begin
          m_col = m_cs; m_row = m_row + 1;
          if (m_row > m_re) m_row = m_rs;
        end
      end
    end
    if (gl) m_vert = gb[2];
    if (acc) m_redraw = 1; else if (clr) m_redraw = 0;
    @(negedge clk);
  endtask

  task automatic wr(logic [7:0] d, string tag);
    cyc(1, d, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state seen through redraw and the first address
    check("R1", "redraw after reset", int'(redraw), 0);
    wr(8'h11, "R1");
    // R1/R3: default window of 64 columns wraps into row 1
    for (int i = 1; i < 64; i++) wr(8'(i), "R3");
    wr(8'h22, "R1");
    check("R3", "row after 65 bytes", int'(mem_addr) >> 6, 1);
    // R8: clear, then clear with simultaneous write (set wins)
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    cyc(1, 8'h33, 0, 0, 0, 0, 0, 0, 0, 0, 1, "R8");
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    // R5/R6: loads with modulo reduction (70 -> 6, 85 -> 5, 81 -> 1)
    cyc(0, 0, 0, 0, 1, 8'd70, 8'd72, 1, 8'd85, 8'd81, 0, "R5");
    wr(8'h44, "R6");
    wr(8'h45, "R5");
    wr(8'h46, "R6");
    // R7: write coincident with a load is dropped
    cyc(1, 8'h55, 0, 0, 1, 8'd2, 8'd4, 0, 0, 0, 0, "R7");
    wr(8'h56, "R7");
    // R4: vertical mode over a 2x3 window
    cyc(0, 0, 1, 8'h04, 1, 8'd10, 8'd11, 1, 8'd20, 8'd22, 0, "R4");
    for (int i = 0; i < 8; i++) wr(8'(i), "R4");
    // R9: first > last on both axes
    cyc(0, 0, 0, 0, 1, 8'd40, 8'd5, 1, 8'd60, 8'd3, 0, "R9");
    for (int i = 0; i < 4; i++) wr(8'(i), "R9");
    cyc(0, 0, 1, 8'hFB, 0, 0, 0, 0, 0, 0, 0, "R4");
    for (int i = 0; i < 4; i++) wr(8'(i), "R9");
    // Constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int p = $urandom % 100;
      bit cl = (p < 4);
      bit rl = (p >= 4 && p < 8);
      bit gl = (($urandom % 100) < 3);
      bit s  = (($urandom % 100) < 70);
      bit clr = (($urandom % 100) < 10);
      cyc(s, 8'($urandom), gl, 8'($urandom), cl, 8'($urandom), 8'($urandom),
          rl, 8'($urandom), 8'($urandom), clr, m_vert ? "R4" : "R3");
    end
    summary();
  end
endmodule